// File: doc/BRIEF.md
# DRAM Power-Down Sequencer

This block sits in a memory controller and owns the clock-enable line of a DDR3-style memory device. When the scheduler asks for power-down, the sequencer takes CKE low, but only if no operation that forbids it is in flight. It records which kind of power-down was entered: active (some bank open), precharge with fast exit, or precharge with slow exit (DLL off). It holds CKE low for at least the minimum low time. For the first cycles after CKE falls, it tells the scheduler to present only NOP or deselect.

When the request is withdrawn, or the count of refresh intervals spent in power-down reaches its limit, the block raises CKE again. It then holds off two classes of command separately. General commands wait for the exit latency. Commands that need the DLL (reads, ODT control) wait for the longer DLL exit latency after a slow exit. A memory-reset input pulls the block out of power-down at once. Leaving reset is treated like a slow exit. All intervals are parameters in clock cycles.

Top module: `dram_pd_sequencer`

## Requirements
- R1: In the idle state, with `pdReq` high, `busyVec` zero, `memRst` low and every exit window elapsed, `cke` is low from the next cycle on.
- R2: Any set bit of `busyVec` (bit0 mode-register write, bit1 MPR access, bit2 ZQ calibration, bit3 DLL locking, bit4 read, bit5 write) keeps `cke` high while `pdReq` is held.
- R3: `pdMode` is 0 outside power-down. At entry it is 1 (active) if any bit of `bankOpen` was set. Otherwise it is 2 (precharge, fast exit) when `fastExitSel` was 1, and 3 (precharge, slow exit) when `fastExitSel` was 0. `fastExitSel` has no effect on an active entry.
- R4: `forceNop` is high during the first T_CPDED cycles with `cke` low, and during the first cycle with `cke` high after an exit. It is low otherwise.
- R5: `cke` stays low for at least max(T_PD, T_CPDED) cycles. Once that is met, it returns high on the cycle after `pdReq` is seen low or `wakeReq` is high.
- R6: After `cke` rises, `genCmdOk` is low for T_XP cycles and then high. A `pdReq` seen before T_CKE, T_XP and the DLL window (R7) have all elapsed is ignored.
- R7: `dllCmdOk` rises T_XPDLL cycles after an exit from slow-exit precharge power-down or from memory reset. After any other exit it rises T_XP cycles after the exit. It is never high while `genCmdOk` is low.
- R8: `refTick` pulses are counted while in power-down. `wakeReq` goes high once WAKE_TICKS have been counted, and it forces an exit even if `pdReq` stays high.
- R9: One cycle after `memRst` is seen high, `cke`, `genCmdOk`, `dllCmdOk` and `pdMode` are all 0. After `memRst` drops, `cke` rises the next cycle and the R7 slow-exit latency applies.
- R10: After `rstN` reset, `cke`, `genCmdOk` and `dllCmdOk` are 1, and `forceNop`, `wakeReq` and `pdMode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| pdReq | input | 1 | Scheduler wants power-down |
| bankOpen | input | NUM_BANKS | One flag per open bank |
| busyVec | input | 6 | In-flight operations that forbid entry |
| fastExitSel | input | 1 | Exit-mode bit from the mode register (1 = fast) |
| memRst | input | 1 | Memory reset asserted |
| refTick | input | 1 | One pulse per refresh interval |
| cke | output | 1 | Clock enable to the memory |
| forceNop | output | 1 | Scheduler must issue NOP/deselect |
| pdMode | output | 2 | 0 none, 1 active, 2 precharge fast, 3 precharge slow |
| genCmdOk | output | 1 | General commands may issue |
| dllCmdOk | output | 1 | DLL-dependent commands may issue |
| wakeReq | output | 1 | Refresh deadline forces exit |

## Verification
Some properties are checked on every cycle by assertions. Each CKE fall into power-down must follow a cycle with no busy flag. It must carry NOP forcing and the mode that bank state implies. The minimum low and high runs of CKE are checked with counters, and the DLL flag is never ahead of the general flag. The exact latencies are shown only by the bench's scenarios, which compare every output against a behavioural model on every clock. These cover each exit flavour's latency, requests that arrive inside exit windows, wake-driven exit with the request still high, and memory reset during power-down.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int BUSY_W = 6;

  typedef enum logic [1:0] {
    PD_NONE     = 2'd0,
    PD_ACTIVE   = 2'd1,
    PD_PRE_FAST = 2'd2,
    PD_PRE_SLOW = 2'd3
  } pdMode_e;

  // Strobes from control to the timer datapath
  typedef struct packed {
    logic enter;
    logic leave;
    logic rstHit;
    logic rstRelease;
  } pdStrobe_t;
endpackage

// File: rtl/pd_seq_timers.sv
module pd_seq_timers
  import pd_seq_pkg::*;
#(
  parameter int T_CPDED    = 2,
  parameter int T_PD       = 4,
  parameter int T_CKE      = 3,
  parameter int T_XP       = 4,
  parameter int T_XPDLL    = 10,
  parameter int WAKE_TICKS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  pdStrobe_t strb,
  input  logic      inPd,
  input  logic      rstState,
  input  logic      refTick,
  output logic      minLowMet,
  output logic      cpdedOn,
  output logic      exitFirst,
  output logic      xpDone,
  output logic      xpdllDone,
  output logic      holdDone,
  output logic      wakeDue
);
  localparam int MIN_LOW = (T_PD > T_CPDED) ? T_PD : T_CPDED;
  localparam int XMAX0   = (T_XP > T_CKE) ? T_XP : T_CKE;
  localparam int XMAX    = (T_XPDLL > XMAX0) ? T_XPDLL : XMAX0;
  localparam int LOW_W   = $clog2(MIN_LOW + 1);
  localparam int X_W     = $clog2(XMAX + 1);
  localparam int T_W     = $clog2(WAKE_TICKS + 1);

  localparam logic [LOW_W-1:0] LOW_MAX   = LOW_W'(MIN_LOW);
  localparam logic [LOW_W-1:0] LOW_NEED  = LOW_W'(MIN_LOW - 1);
  localparam logic [LOW_W-1:0] CPDED_LIM = LOW_W'(T_CPDED);
  localparam logic [X_W-1:0]   X_MAX     = X_W'(XMAX);
  localparam logic [X_W-1:0]   X_XP      = X_W'(T_XP);
  localparam logic [X_W-1:0]   X_XPDLL   = X_W'(T_XPDLL);
  localparam logic [X_W-1:0]   X_CKE     = X_W'(T_CKE);
  localparam logic [T_W-1:0]   TICK_MAX  = T_W'(WAKE_TICKS);

  logic [LOW_W-1:0] lowCnt;
  logic [X_W-1:0]   exitCnt;
  logic [T_W-1:0]   tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      tickCnt <= '0;
      exitCnt <= X_MAX;
    end else begin
      if (strb.enter) begin
        lowCnt  <= '0;
        tickCnt <= '0;
      end else if (inPd) begin
        if (lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;
        if (refTick && tickCnt != TICK_MAX) tickCnt <= tickCnt + 1'b1;
      end
      if (strb.leave || strb.rstRelease) exitCnt <= '0;
      else if (!inPd && !rstState && exitCnt != X_MAX) exitCnt <= exitCnt + 1'b1;
    end
  end

  assign minLowMet = (lowCnt >= LOW_NEED);
  assign cpdedOn   = (lowCnt < CPDED_LIM);
  assign exitFirst = (exitCnt == '0);
  assign xpDone    = (exitCnt >= X_XP);
  assign xpdllDone = (exitCnt >= X_XPDLL);
  assign holdDone  = (exitCnt >= X_CKE);
  assign wakeDue   = (tickCnt >= TICK_MAX);
endmodule

// File: rtl/pd_seq_ctrl.sv
module pd_seq_ctrl
  import pd_seq_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [BUSY_W-1:0]    busyVec,
  input  logic                 fastExitSel,
  input  logic                 memRst,
  input  logic                 minLowMet,
  input  logic                 cpdedOn,
  input  logic                 exitFirst,
  input  logic                 xpDone,
  input  logic                 xpdllDone,
  input  logic                 holdDone,
  input  logic                 wakeDue,
  output pdStrobe_t            strb,
  output logic                 inPd,
  output logic                 rstState,
  output logic                 cke,
  output logic                 forceNop,
  output pdMode_e              pdMode,
  output logic                 genCmdOk,
  output logic                 dllCmdOk,
  output logic                 wakeReq
);
  pdMode_e modeQ;
  logic    slowExit;
  logic    idle;
  logic    dllWinDone;

  assign idle       = !inPd && !rstState;
  assign dllWinDone = slowExit ? xpdllDone : xpDone;
  assign wakeReq    = inPd && wakeDue;

  always_comb begin
    strb.rstHit     = memRst;
    strb.rstRelease = !memRst && rstState;
    strb.enter      = !memRst && idle && pdReq && (busyVec == '0)
                      && holdDone && xpDone && dllWinDone;
    strb.leave      = !memRst && inPd && minLowMet && (!pdReq || wakeDue);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPd     <= 1'b0;
      rstState <= 1'b0;
      modeQ    <= PD_NONE;
      slowExit <= 1'b0;
    end else if (strb.rstHit) begin
      rstState <= 1'b1;
      inPd     <= 1'b0;
      modeQ    <= PD_NONE;
    end else if (strb.rstRelease) begin
      rstState <= 1'b0;
      slowExit <= 1'b1;
    end else if (strb.enter) begin
      inPd <= 1'b1;
      if (|bankOpen)        modeQ <= PD_ACTIVE;
      else if (fastExitSel) modeQ <= PD_PRE_FAST;
      else                  modeQ <= PD_PRE_SLOW;
    end else if (strb.leave) begin
      inPd     <= 1'b0;
      slowExit <= (modeQ == PD_PRE_SLOW);
      modeQ    <= PD_NONE;
    end
  end

  assign cke      = idle;
  assign forceNop = (inPd && cpdedOn) || (idle && exitFirst);
  assign pdMode   = modeQ;
  assign genCmdOk = idle && xpDone;
  assign dllCmdOk = idle && dllWinDone;
endmodule

// File: rtl/dram_pd_sequencer.sv
module dram_pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int T_CPDED    = 2,
  parameter int T_PD       = 4,
  parameter int T_CKE      = 3,
  parameter int T_XP       = 4,
  parameter int T_XPDLL    = 10,
  parameter int WAKE_TICKS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [BUSY_W-1:0]    busyVec,
  input  logic                 fastExitSel,
  input  logic                 memRst,
  input  logic                 refTick,
  output logic                 cke,
  output logic                 forceNop,
  output logic [1:0]           pdMode,
  output logic                 genCmdOk,
  output logic                 dllCmdOk,
  output logic                 wakeReq
);
  pdStrobe_t strb;
  pdMode_e   modeE;
  logic inPd, rstState;
  logic minLowMet, cpdedOn, exitFirst, xpDone, xpdllDone, holdDone, wakeDue;

  pd_seq_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .bankOpen(bankOpen),
    .busyVec(busyVec), .fastExitSel(fastExitSel), .memRst(memRst),
    .minLowMet(minLowMet), .cpdedOn(cpdedOn), .exitFirst(exitFirst),
    .xpDone(xpDone), .xpdllDone(xpdllDone), .holdDone(holdDone),
    .wakeDue(wakeDue), .strb(strb), .inPd(inPd), .rstState(rstState),
    .cke(cke), .forceNop(forceNop), .pdMode(modeE), .genCmdOk(genCmdOk),
    .dllCmdOk(dllCmdOk), .wakeReq(wakeReq)
  );

  pd_seq_timers #(
    .T_CPDED(T_CPDED), .T_PD(T_PD), .T_CKE(T_CKE), .T_XP(T_XP),
    .T_XPDLL(T_XPDLL), .WAKE_TICKS(WAKE_TICKS)
  ) u_tmr (
    .clk(clk), .rstN(rstN), .strb(strb), .inPd(inPd), .rstState(rstState),
    .refTick(refTick), .minLowMet(minLowMet), .cpdedOn(cpdedOn),
    .exitFirst(exitFirst), .xpDone(xpDone), .xpdllDone(xpdllDone),
    .holdDone(holdDone), .wakeDue(wakeDue)
  );

  assign pdMode = modeE;
endmodule

// File: rtl/pd_seq_checker.sv
module pd_seq_checker #(
  parameter int NUM_BANKS = 8,
  parameter int T_CPDED   = 2,
  parameter int T_PD      = 4,
  parameter int T_CKE     = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pdReq,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic [5:0]           busyVec,
  input logic                 memRst,
  input logic                 cke,
  input logic                 forceNop,
  input logic [1:0]           pdMode,
  input logic                 genCmdOk,
  input logic                 dllCmdOk,
  input logic                 wakeReq
);
  localparam int MIN_LOW = (T_PD > T_CPDED) ? T_PD : T_CPDED;
  logic [15:0] lowRun, highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 16'hFFFF;
    end else if (cke) begin
      lowRun  <= '0;
      if (highRun != 16'hFFFF) highRun <= highRun + 1'b1;
    end else begin
      highRun <= '0;
      if (lowRun != 16'hFFFF) lowRun <= lowRun + 1'b1;
    end
  end

  // R1 / R2: entry only after a request with no busy operation
  a_r2_no_busy_entry: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && pdMode != 2'd0) |-> ($past(busyVec) == '0 && $past(pdReq)));
  // R4: NOP forcing on the first low cycle
  a_r4_nop_at_entry: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && pdMode != 2'd0) |-> forceNop);
  // R3: active mode exactly when a bank was open
  a_r3_mode_class: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && pdMode != 2'd0) |-> ((pdMode == 2'd1) == $past(|bankOpen)));
  // R5: minimum low run before exit
  a_r5_min_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cke) && $past(pdMode) != 2'd0) |-> (lowRun >= 16'(MIN_LOW)));
  // R6: minimum high run before re-entry
  a_r6_min_high: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cke) && pdMode != 2'd0) |-> (highRun >= 16'(T_CKE)));
  // R6: commands only with clock enabled
  a_r6_gen_needs_cke: assert property (@(posedge clk) disable iff (!rstN)
    genCmdOk |-> (cke && pdMode == 2'd0));
  // R7: DLL class never ahead of general class
  a_r7_dll_after_gen: assert property (@(posedge clk) disable iff (!rstN)
    dllCmdOk |-> genCmdOk);
  // R8: wake only inside power-down
  a_r8_wake_in_pd: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (!cke && pdMode != 2'd0));
  // R9: memory reset forces everything off
  a_r9_mem_reset: assert property (@(posedge clk) disable iff (!rstN)
    $past(memRst) |-> (!cke && !genCmdOk && !dllCmdOk && pdMode == 2'd0));
endmodule

bind dram_pd_sequencer pd_seq_checker #(
  .NUM_BANKS(NUM_BANKS), .T_CPDED(T_CPDED), .T_PD(T_PD), .T_CKE(T_CKE)
) u_chk (
  .clk(clk), .rstN(rstN), .pdReq(pdReq), .bankOpen(bankOpen),
  .busyVec(busyVec), .memRst(memRst), .cke(cke), .forceNop(forceNop),
  .pdMode(pdMode), .genCmdOk(genCmdOk), .dllCmdOk(dllCmdOk), .wakeReq(wakeReq)
);

// File: tb/dram_pd_sequencer_tb.sv
module dram_pd_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, TCP = 2, TPD = 4, TCKE = 3, TXP = 4, TXPDLL = 10, WAKE = 8;
  localparam int MINLOW = (TPD > TCP) ? TPD : TCP;

  logic clk = 1'b0, rstN = 1'b0;
  logic pdReq = 1'b0, fastExitSel = 1'b0, memRst = 1'b0, refTick = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic [5:0] busyVec = '0;
  logic cke, forceNop, genCmdOk, dllCmdOk, wakeReq;
  logic [1:0] pdMode;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_pd_sequencer #(.NUM_BANKS(NB), .T_CPDED(TCP), .T_PD(TPD), .T_CKE(TCKE),
    .T_XP(TXP), .T_XPDLL(TXPDLL), .WAKE_TICKS(WAKE)) u_dut (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .bankOpen(bankOpen), .busyVec(busyVec),
    .fastExitSel(fastExitSel), .memRst(memRst), .refTick(refTick), .cke(cke),
    .forceNop(forceNop), .pdMode(pdMode), .genCmdOk(genCmdOk),
    .dllCmdOk(dllCmdOk), .wakeReq(wakeReq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 awake, 1 powered down, 2 memory reset
  int phase = 0, mode = 0, lowCycles = 0, sinceExit = 1000, ticks = 0;
  bit slowPending = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; mode = 0; lowCycles = 0; sinceExit = 1000; ticks = 0; slowPending = 0;
    end else if (memRst) begin
      phase = 2; mode = 0;
    end else if (phase == 2) begin
      phase = 0; sinceExit = 0; slowPending = 1;
    end else if (phase == 1) begin
      if (lowCycles >= MINLOW - 1 && (!pdReq || ticks >= WAKE)) begin
        phase = 0; sinceExit = 0; slowPending = (mode == 3); mode = 0;
      end else begin
        lowCycles++;
        if (refTick) ticks++;
      end
    end else begin
      if (pdReq && busyVec == 0 && sinceExit >= TCKE && sinceExit >= TXP &&
          sinceExit >= (slowPending ? TXPDLL : TXP)) begin
        phase = 1; lowCycles = 0; ticks = 0;
        mode = (bankOpen != 0) ? 1 : (fastExitSel ? 2 : 3);
      end else if (sinceExit < 1000) sinceExit++;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit eCke, eNop, eGen, eDll, eWake;
      eCke  = (phase == 0);
      eNop  = (phase == 1 && lowCycles < TCP) || (phase == 0 && sinceExit == 0);
      eGen  = (phase == 0 && sinceExit >= TXP);
      eDll  = (phase == 0 && sinceExit >= (slowPending ? TXPDLL : TXP));
      eWake = (phase == 1 && ticks >= WAKE);
      chk(cke == eCke, "R1/R5 cke", cke, eCke);
      chk(forceNop == eNop, "R4 forceNop", forceNop, eNop);
      chk(pdMode == 2'(mode), "R3 pdMode", pdMode, mode);
      chk(genCmdOk == eGen, "R6 genCmdOk", genCmdOk, eGen);
      chk(dllCmdOk == eDll, "R7 dllCmdOk", dllCmdOk, eDll);
      chk(wakeReq == eWake, "R8 wakeReq", wakeReq, eWake);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R10 reset state
    chk(cke && genCmdOk && dllCmdOk && !forceNop && !wakeReq && pdMode == 0,
        "R10 reset state", {cke, genCmdOk, dllCmdOk, forceNop, wakeReq}, 5'b11100);

    // R2: each busy flag blocks entry
    for (int i = 0; i < 6; i++) begin
      busyVec = 6'(1 << i); pdReq = 1'b1;
      cyc(3);
      chk(cke == 1'b1, "R2 busy blocks entry", cke, 1);
      busyVec = '0; pdReq = 1'b0;
      cyc(1);
    end

    // R1/R3 slow-exit precharge, R7 long DLL window
    fastExitSel = 1'b0; bankOpen = '0; pdReq = 1'b1;
    cyc(1);
    chk(!cke && pdMode == 3, "R1 R3 slow entry", pdMode, 3);
    cyc(6);
    pdReq = 1'b0;
    cyc(1);
    chk(cke && forceNop && !genCmdOk, "R4 R6 exit cycle", {cke, forceNop, genCmdOk}, 3'b110);
    cyc(TXP);
    chk(genCmdOk && !dllCmdOk, "R7 dll still blocked", dllCmdOk, 0);
    cyc(TXPDLL - TXP);
    chk(dllCmdOk, "R7 dll after slow exit", dllCmdOk, 1);

    // R3 fast-exit precharge; short request tests R5 minimum low time
    fastExitSel = 1'b1; pdReq = 1'b1;
    cyc(1);
    chk(pdMode == 2, "R3 fast precharge", pdMode, 2);
    pdReq = 1'b0;
    cyc(MINLOW - 1);
    chk(!cke, "R5 held low", cke, 0);
    cyc(1);
    chk(cke, "R5 exit after minimum", cke, 1);
    // R6: re-request inside exit windows ignored
    pdReq = 1'b1;
    cyc(1);
    chk(cke, "R6 request ignored in window", cke, 1);
    cyc(TXP + 2);
    pdReq = 1'b0;
    cyc(MINLOW + TXP + 2);

    // R3 active: exit bit ignored, R7 short window
    bankOpen = 8'h10; fastExitSel = 1'b0; pdReq = 1'b1;
    cyc(1);
    chk(pdMode == 1, "R3 active ignores exit bit", pdMode, 1);
    cyc(5);
    pdReq = 1'b0;
    cyc(1 + TXP);
    chk(dllCmdOk, "R7 dll after active exit", dllCmdOk, 1);
    bankOpen = '0;

    // R8: wake forces exit with request held
    fastExitSel = 1'b1; pdReq = 1'b1;
    cyc(1);
    for (int t = 0; t < WAKE; t++) begin
      refTick = 1'b1; cyc(1); refTick = 1'b0; cyc(2);
    end
    chk(wakeReq || cke, "R8 wake raised or exit taken", {wakeReq, cke}, 2'b10);
    cyc(2);
    chk(cke, "R8 exit despite request", cke, 1);
    pdReq = 1'b0;
    cyc(TXPDLL + 2);

    // R9: memory reset during power-down
    pdReq = 1'b1; fastExitSel = 1'b1;
    cyc(3);
    memRst = 1'b1;
    cyc(1);
    chk(!cke && pdMode == 0 && !genCmdOk, "R9 reset state", pdMode, 0);
    pdReq = 1'b0;
    cyc(2);
    memRst = 1'b0;
    cyc(1);
    chk(cke && !dllCmdOk, "R9 release acts as slow exit", cke, 1);
    cyc(TXPDLL);
    chk(dllCmdOk, "R9 R7 dll after reset release", dllCmdOk, 1);

    cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule